// File: doc/BRIEF.md
# Ethernet Frame Check Sequence Generator

This block sits in an Ethernet transmit path and appends the 32-bit frame check sequence to a payload byte stream. Bytes arrive one per clock with a valid strobe. A start strobe marks the first byte of a frame and an end strobe marks its last byte. Every accepted byte is passed to the output one cycle later. The checksum register is updated by a full octet in each accepted cycle.

After the last payload byte, the block emits the four check bytes on the next four cycles. While it does so, it drops its ready output and ignores the input. The remainder goes through three steps before it leaves: each octet is bit-reversed, the whole value is inverted, and the four bytes are sent in the order the line expects.

Preamble, start delimiter, padding, interframe gap and receive-side checking belong to other blocks.

Top module: `eth_fcs_gen`

## Requirements
- R1: While reset is held, `out_valid` and `out_last` are low and `in_ready` is high.
- R2: A payload byte accepted at a clock edge (`in_valid` and `in_ready` high) appears on `out_data` after the next edge. At that point `out_valid` is high and `out_last` is low.
- R3: A byte with `frame_start` high presets the checksum register to all ones before that byte is folded in. The check bytes of a frame therefore do not depend on earlier frames, even when frames follow each other with no idle cycle.
- R4: Payload bytes offered on consecutive cycles are all accepted, one per clock, with no stall.
- R5: Exactly four check bytes follow the byte that carried `in_end`, on the four consecutive cycles right after it. `out_last` is high only on the fourth of them.
- R6: `in_ready` is low from the edge that accepts the end byte until the fourth check byte is on the output. Input offered in that window is dropped and leaves the checksum unchanged.
- R7: The checksum uses polynomial 0x04C11DB7. Each input byte is folded in bit 0 first. Check byte k (k = 0..3, sent first to last) is the inverse of the bit-reversed register octet at bits [31-8k : 24-8k]. For the nine ASCII bytes "123456789" the check bytes are 0x26, 0x39, 0xF4, 0xCB.
- R8: Running the same checksum (preset all ones, bit 0 first) over the full output frame, payload plus check bytes, leaves the register at 0xC704DD7B.
- R9: A cycle with `in_valid` low inside a frame produces a cycle with `out_valid` low and does not change the checksum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| frame_start | input | 1 | Marks the current byte as the first of a frame |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input payload byte |
| in_end | input | 1 | Marks the current byte as the last payload byte |
| in_ready | output | 1 | Block can accept a byte this cycle |
| out_valid | output | 1 | Output byte present |
| out_data | output | 8 | Payload byte or check byte |
| out_last | output | 1 | Final check byte of the frame |

## Verification
A wrong checksum register stays hidden while the payload is passing through. It shows only in the four check bytes after the end byte, so the bench checks every one of them against an independent reflected model and against the fixed receive residue. A wrong tail counter or phase shows within a cycle as a missing or extra valid beat, a misplaced last flag, or a ready level that disagrees with the model. These are compared on every clock. Stray input offered during the tail would show as an extra output byte or as wrong check bytes in the frame that follows.

// File: rtl/eth_fcs_pkg.sv
package eth_fcs_pkg;

    localparam int CRC_W     = 32;
    localparam int BYTE_W    = 8;
    localparam int FCS_BYTES = CRC_W / BYTE_W;
    localparam int IDX_W     = $clog2(FCS_BYTES);

    localparam logic [CRC_W-1:0] CRC_POLY   = 32'h04C1_1DB7;
    localparam logic [CRC_W-1:0] CRC_PRESET = '1;

    typedef logic [CRC_W-1:0]  crc_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic {PH_DATA, PH_TAIL} phase_e;

    typedef struct packed {
        logic  valid;
        logic  last;
        byte_t data;
    } beat_t;

    // Folds one octet into the register, bit 0 of the octet first;
    // unrolled into a single XOR network per clock.
    function automatic crc_t crc_fold_byte(crc_t c, byte_t d);
        crc_t r;
        logic fb;
        r = c;
        for (int i = 0; i < BYTE_W; i++) begin
            fb = r[CRC_W-1] ^ d[i];
            r  = {r[CRC_W-2:0], 1'b0};
            if (fb) r = r ^ CRC_POLY;
        end
        return r;
    endfunction

    function automatic byte_t rev_octet(byte_t b);
        byte_t r;
        for (int i = 0; i < BYTE_W; i++) r[i] = b[BYTE_W-1-i];
        return r;
    endfunction

    // Line byte k of the check sequence: top octet of the register first,
    // each one bit-reversed and inverted.
    function automatic byte_t fcs_line_byte(crc_t c, logic [IDX_W-1:0] k);
        byte_t oct;
        oct = c[CRC_W-1-BYTE_W*int'(k) -: BYTE_W];
        return ~rev_octet(oct);
    endfunction

endpackage

// File: rtl/fcs_crc_engine.sv
module fcs_crc_engine
    import eth_fcs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  take,
    input  logic  restart,
    input  byte_t data,
    output crc_t  crc_q
);
    crc_t seed;
    crc_t crc_d;

    always_comb begin
        seed  = restart ? CRC_PRESET : crc_q;
        crc_d = crc_fold_byte(seed, data);
    end

    always_ff @(posedge clk) begin
        if (rst)       crc_q <= CRC_PRESET;
        else if (take) crc_q <= crc_d;
    end

    AST_IDLE_HOLDS_CRC: assert property (@(posedge clk) disable iff (rst)
        !take |=> $stable(crc_q)); // R9

endmodule

// File: rtl/fcs_tail_seq.sv
module fcs_tail_seq
    import eth_fcs_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   take,
    input  logic   end_i,
    input  byte_t  data,
    input  crc_t   crc_q,
    output beat_t  beat,
    output phase_e phase
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FCS_BYTES - 1);

    logic [IDX_W-1:0] idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_DATA;
            idx   <= '0;
            beat  <= '0;
        end else begin
            case (phase)
                PH_DATA: begin
                    beat.valid <= take;
                    beat.last  <= 1'b0;
                    beat.data  <= data;
                    idx        <= '0;
                    if (take && end_i) phase <= PH_TAIL;
                end
                PH_TAIL: begin
                    beat.valid <= 1'b1;
                    beat.last  <= (idx == LAST_IDX);
                    beat.data  <= fcs_line_byte(crc_q, idx);
                    idx        <= idx + 1'b1;
                    if (idx == LAST_IDX) phase <= PH_DATA;
                end
                default: phase <= PH_DATA;
            endcase
        end
    end

    AST_LAST_HAS_VALID: assert property (@(posedge clk) disable iff (rst)
        beat.last |-> beat.valid); // R5
    AST_LAST_SINGLE: assert property (@(posedge clk) disable iff (rst)
        beat.last |=> !beat.last); // R5
    AST_TAIL_STEADY: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_TAIL) |=> beat.valid); // R5

endmodule

// File: rtl/eth_fcs_gen.sv
module eth_fcs_gen
    import eth_fcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_start,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_end,
    output logic       in_ready,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       out_last
);
    crc_t   crc_q;
    beat_t  beat;
    phase_e phase;
    logic   take;

    assign in_ready = (phase == PH_DATA);
    assign take     = in_valid && in_ready;

    fcs_crc_engine i_engine (
        .clk     (clk),
        .rst     (rst),
        .take    (take),
        .restart (frame_start),
        .data    (in_data),
        .crc_q   (crc_q)
    );

    fcs_tail_seq i_tail (
        .clk   (clk),
        .rst   (rst),
        .take  (take),
        .end_i (in_end),
        .data  (in_data),
        .crc_q (crc_q),
        .beat  (beat),
        .phase (phase)
    );

    assign out_valid = beat.valid;
    assign out_data  = beat.data;
    assign out_last  = beat.last;

    AST_READY_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        out_last |-> in_ready); // R6
    AST_TAIL_FREEZES_CRC: assert property (@(posedge clk) disable iff (rst)
        !in_ready |=> $stable(crc_q)); // R6

endmodule

// File: tb/test_eth_fcs_gen.sv
module test_eth_fcs_gen;
    logic       clk = 1'b0;
    logic       rst;
    logic       frame_start, in_valid, in_end;
    logic [7:0] in_data;
    logic       in_ready, out_valid, out_last;
    logic [7:0] out_data;

    always #10 clk = ~clk;

    eth_fcs_gen i_eth_fcs_gen (
        .clk(clk), .rst(rst), .frame_start(frame_start), .in_valid(in_valid),
        .in_data(in_data), .in_end(in_end), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
    );

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [31:0] m_crc;
    logic [7:0]  tail_q[$];
    logic [7:0]  cap_q[$];
    logic [31:0] last4;

    // Reflected bytewise model, independent of the register layout in the design.
    function automatic logic [31:0] ref_upd(logic [31:0] c, logic [7:0] b);
        c = c ^ {24'd0, b};
        for (int i = 0; i < 8; i++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
        return c;
    endfunction

    function automatic logic [31:0] rev32(logic [31:0] v);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[i] = v[31-i];
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One clock: drive at negedge, model the next output beat, compare at next negedge.
    task automatic tick(input logic v, input logic [7:0] d, input logic s, input logic e);
        logic       ev, el;
        logic [7:0] ed;
        string      tag;
        frame_start = s; in_valid = v; in_data = d; in_end = e;
        ev = 0; el = 0; ed = 8'h00; tag = "R9";
        if (tail_q.size() > 0) begin
            ev = 1; ed = tail_q.pop_front(); el = (tail_q.size() == 0); tag = "R5";
        end else if (v) begin
            m_crc = ref_upd(s ? 32'hFFFF_FFFF : m_crc, d);
            ev = 1; ed = d; tag = "R4";
            if (e) for (int k = 0; k < 4; k++) tail_q.push_back(~m_crc[8*k +: 8]);
        end
        @(posedge clk);
        @(negedge clk);
        chk(out_valid == ev, tag, "out_valid", 32'(out_valid), 32'(ev));
        chk(out_last == el, "R5", "out_last", 32'(out_last), 32'(el));
        chk(in_ready == (tail_q.size() == 0), "R6", "in_ready",
            32'(in_ready), 32'(tail_q.size() == 0));
        if (ev && out_valid)
            chk(out_data == ed, (tag == "R5") ? "R7" : "R2", "out_data", 32'(out_data), 32'(ed));
        if (out_valid) begin
            cap_q.push_back(out_data);
            last4 = {last4[23:0], out_data};
        end
        if (out_valid && out_last) begin
            logic [31:0] r;
            r = 32'hFFFF_FFFF;
            foreach (cap_q[i]) r = ref_upd(r, cap_q[i]);
            chk(rev32(r) == 32'hC704_DD7B, "R8", "residue", rev32(r), 32'hC704_DD7B);
            cap_q.delete();
        end
    endtask

    task automatic send(input logic [7:0] b[$], input int gap_every, input bit junk);
        for (int i = 0; i < b.size(); i++) begin
            if (gap_every > 0 && i > 0 && (i % gap_every) == 0) tick(0, 8'h5A, 0, 0); // R9 gap
            tick(1, b[i], i == 0, i == b.size() - 1);
        end
        for (int k = 0; k < 4; k++) tick(junk, 8'hEE, junk, junk); // R6 ignored input
    endtask

    logic [7:0] std9[$];
    logic [7:0] fr[$];

    initial begin
        rst = 1; frame_start = 0; in_valid = 0; in_data = 0; in_end = 0;
        m_crc = 32'hFFFF_FFFF; last4 = 0;
        repeat (3) @(negedge clk);
        chk(!out_valid && !out_last && in_ready, "R1", "reset outputs",
            {29'd0, out_valid, out_last, in_ready}, 32'h1);
        rst = 0;
        tick(0, 0, 0, 0);

        std9 = {8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
        send(std9, 0, 0);
        chk(last4 == 32'h2639_F4CB, "R7", "known check bytes", last4, 32'h2639_F4CB);
        tick(0, 0, 0, 0);

        fr.delete();
        for (int i = 0; i < 20; i++) fr.push_back(8'(i * 37 + 5));
        send(fr, 3, 1);           // gaps inside frame, junk during tail
        send(std9, 0, 0);         // back to back, register must restart
        chk(last4 == 32'h2639_F4CB, "R3", "preset on start", last4, 32'h2639_F4CB);

        fr.delete(); fr.push_back(8'hA5);
        send(fr, 0, 1);           // single-byte frame
        tick(0, 0, 0, 0);

        fr.delete();
        for (int i = 0; i < 64; i++) fr.push_back(8'((i * 13) ^ 8'hC3));
        send(fr, 0, 0);
        fr.delete();
        for (int i = 0; i < 46; i++) fr.push_back(8'hFF);
        send(fr, 5, 1);
        tick(0, 0, 0, 0);
        tick(0, 0, 0, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule